// File: doc/BRIEF.md
# Floating-Point Issue Hazard Tracker

This block sits beside the issue stage of an in-order core and decides, one cycle at a time, whether a floating-point operation offered by the issue logic may start. Three shared resources are tracked. The add pipe is fully pipelined and is taken only in the cycle an operation starts. The multiply pipe is pipelined for single-precision work, but double-precision multiplies and multiply-accumulates reserve it for several further cycles. The divide/square-root unit is not pipelined and stays reserved for a long stretch after it starts.

Each cycle the requester presents a valid bit and an operation code. The tracker answers with a combinational grant in the same cycle. A refused request leaves no trace, and the requester must offer it again. Work that needs a free resource can start while another resource is still reserved, so add-class work fills the gaps of a long multiply, and later operations overtake a running divide. Operand dependencies and result writeback are handled elsewhere.

Top module: `fpht_hazard_tracker`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, grant, add_busy, mul_busy and div_busy are all 0.
- R2: An add-class request (req_op 0 for add/compare/convert/move, or 8 for constant load) is granted in the cycle it is offered, whatever the state of the multiply and divide resources, and add_busy is 1 in that cycle only.
- R3: A single-precision multiply (req_op 1) or single-precision multiply-accumulate (req_op 3) holds the multiply pipe only in its start cycle, so another multiply offered in the next cycle is granted and mul_busy stays 0.
- R4: A double-precision multiply (req_op 2) or double-precision multiply-accumulate (req_op 4) reserves the multiply pipe for 3 cycles after its start: mul_busy is 1 in those cycles, and a multiply-class request (req_op 1 to 5) there is refused; one offered continuously is granted 4 cycles after the start.
- R5: A double-precision fused multiply-add (req_op 5) reserves the multiply pipe for 4 cycles after its start; a multiply offered continuously is granted 5 cycles after the start.
- R6: A single-precision divide or square root (req_op 6) reserves the divider for 13 cycles after its start, during which div_busy is 1 and a divider request (req_op 6 or 7) is refused; one offered continuously is granted 14 cycles after the start.
- R7: A double-precision divide or square root (req_op 7) reserves the divider for 28 cycles after its start; a divider request offered continuously is granted 29 cycles after the start.
- R8: A refused request does not extend or restart any reservation: the resource frees at the cycle set by the operation that was granted.
- R9: The multiply pipe and the divider are independent: either one can start work while the other is reserved.
- R10: With req_valid low, or with a req_op from 9 to 15, grant is 0 and no busy flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An operation is offered this cycle |
| req_op | input | 4 | Operation code of the offered operation |
| grant | output | 1 | The offered operation starts this cycle |
| add_busy | output | 1 | Add pipe taken by an operation starting this cycle |
| mul_busy | output | 1 | Multiply pipe reserved by an earlier operation |
| div_busy | output | 1 | Divider reserved by an earlier operation |

## Verification
The hardest case is a request that keeps being refused while a reservation counts down, since a design that reloaded or stretched the reservation on a refused offer would look correct for isolated requests. The stimulus therefore offers the blocked operation on every cycle after a long multiply or divide and measures the exact cycle of the first grant, then repeats this with a different, longer operation refused in between. Add-class and cross-resource requests are interleaved into the same windows to show the gaps are usable.

// File: rtl/fpht_pkg.sv
package fpht_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_MULS  = 4'd1,
    OP_MULD  = 4'd2,
    OP_MACS  = 4'd3,
    OP_MACD  = 4'd4,
    OP_FMAD  = 4'd5,
    OP_DIVS  = 4'd6,
    OP_DIVD  = 4'd7,
    OP_CONST = 4'd8
  } fp_op_e;

  typedef struct packed {
    logic add;
    logic mul;
    logic div;
  } fp_cls_t;

endpackage

// File: rtl/fpht_decode.sv
module fpht_decode
  import fpht_pkg::*;
#(
  parameter int MUL_W       = 3,
  parameter int DIV_W       = 5,
  parameter int MUL_D_EXTRA = 3,
  parameter int FMA_D_EXTRA = 4,
  parameter int DIV_S_EXTRA = 13,
  parameter int DIV_D_EXTRA = 28
) (
  input  logic [3:0]       op,
  output fp_cls_t          cls,
  output logic [MUL_W-1:0] mul_hold,
  output logic [DIV_W-1:0] div_hold
);

  always_comb begin
    cls      = '0;
    mul_hold = '0;
    div_hold = '0;
    case (op)
      OP_ADD, OP_CONST: cls.add = 1'b1;
      OP_MULS, OP_MACS: cls.mul = 1'b1;
      OP_MULD, OP_MACD: begin
        cls.mul  = 1'b1;
        mul_hold = MUL_W'(MUL_D_EXTRA);
      end
      OP_FMAD: begin
        cls.mul  = 1'b1;
        mul_hold = MUL_W'(FMA_D_EXTRA);
      end
      OP_DIVS: begin
        cls.div  = 1'b1;
        div_hold = DIV_W'(DIV_S_EXTRA);
      end
      OP_DIVD: begin
        cls.div  = 1'b1;
        div_hold = DIV_W'(DIV_D_EXTRA);
      end
      default: cls = '0;
    endcase
  end

endmodule

// File: rtl/fpht_hold_cnt.sv
module fpht_hold_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/fpht_hazard_tracker.sv
module fpht_hazard_tracker
  import fpht_pkg::*;
#(
  parameter int MUL_D_EXTRA = 3,
  parameter int FMA_D_EXTRA = 4,
  parameter int DIV_S_EXTRA = 13,
  parameter int DIV_D_EXTRA = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_op,
  output logic       grant,
  output logic       add_busy,
  output logic       mul_busy,
  output logic       div_busy
);

  localparam int MUL_MAX = (MUL_D_EXTRA > FMA_D_EXTRA) ? MUL_D_EXTRA : FMA_D_EXTRA;
  localparam int DIV_MAX = (DIV_S_EXTRA > DIV_D_EXTRA) ? DIV_S_EXTRA : DIV_D_EXTRA;
  localparam int MUL_W   = $clog2(MUL_MAX + 1);
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  fp_cls_t          cls;
  logic [MUL_W-1:0] mul_hold;
  logic [DIV_W-1:0] div_hold;
  logic             mul_start;
  logic             div_start;

  fpht_decode #(
    .MUL_W(MUL_W), .DIV_W(DIV_W),
    .MUL_D_EXTRA(MUL_D_EXTRA), .FMA_D_EXTRA(FMA_D_EXTRA),
    .DIV_S_EXTRA(DIV_S_EXTRA), .DIV_D_EXTRA(DIV_D_EXTRA)
  ) u_dec (
    .op(req_op), .cls(cls), .mul_hold(mul_hold), .div_hold(div_hold)
  );

  always_comb begin
    mul_start = req_valid & cls.mul & ~mul_busy;
    div_start = req_valid & cls.div & ~div_busy;
    add_busy  = req_valid & cls.add;
    grant     = add_busy | mul_start | div_start;
  end

  fpht_hold_cnt #(.W(MUL_W)) u_mul_cnt (
    .clk(clk), .rst_n(rst_n), .load(mul_start), .load_val(mul_hold), .busy(mul_busy)
  );

  fpht_hold_cnt #(.W(DIV_W)) u_div_cnt (
    .clk(clk), .rst_n(rst_n), .load(div_start), .load_val(div_hold), .busy(div_busy)
  );

endmodule

// File: rtl/fpht_chk.sv
module fpht_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       grant,
  input logic       add_busy,
  input logic       mul_busy,
  input logic       div_busy
);

  logic is_mul_op;
  logic is_div_op;
  logic is_add_op;
  assign is_mul_op = (req_op >= 4'd1) && (req_op <= 4'd5);
  assign is_div_op = (req_op == 4'd6) || (req_op == 4'd7);
  assign is_add_op = (req_op == 4'd0) || (req_op == 4'd8);

  AST_ADD_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_add_op) |-> (grant && add_busy)); // R2
  AST_SHORT_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (req_op == 4'd1 || req_op == 4'd3)) |=> !mul_busy); // R3
  AST_MUL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_mul_op && mul_busy) |-> !grant); // R4
  AST_MULD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (req_op == 4'd2 || req_op == 4'd4 || req_op == 4'd5)) |=> mul_busy); // R5
  AST_DIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_div_op && div_busy) |-> !grant); // R6
  AST_DIVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_op == 4'd7) |=> div_busy); // R7
  AST_MUL_WHILE_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_mul_op && !mul_busy) |-> grant); // R9
  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op > 4'd8) |-> !grant); // R10
  AST_NO_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op > 4'd8) |=> !$rose(mul_busy) && !$rose(div_busy)); // R10

endmodule

bind fpht_hazard_tracker fpht_chk u_chk (.*);

// File: tb/sim_fpht_hazard_tracker.sv
module sim_fpht_hazard_tracker;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_op;
  logic       grant, add_busy, mul_busy, div_busy;

  int checks = 0;
  int errors = 0;
  int m_left = 0;
  int d_left = 0;
  bit last_grant;
  bit done = 0;

  fpht_hazard_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .grant(grant), .add_busy(add_busy), .mul_busy(mul_busy), .div_busy(div_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int mul_hold(input int op);
    case (op)
      2, 4:    return 3;
      5:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int div_hold(input int op);
    return (op == 6) ? 13 : 28;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int op, input string tag);
    bit is_mul, is_div, is_add, eg;
    @(negedge clk);
    req_valid = v;
    req_op    = 4'(op);
    #1;
    is_mul = v && op >= 1 && op <= 5;
    is_div = v && (op == 6 || op == 7);
    is_add = v && (op == 0 || op == 8);
    eg = is_add || (is_mul && m_left == 0) || (is_div && d_left == 0);
    check(tag, "grant", grant, eg);
    check(tag, "add_busy", add_busy, is_add);
    check(tag, "mul_busy", mul_busy, m_left > 0);
    check(tag, "div_busy", div_busy, d_left > 0);
    if (eg && is_mul)  m_left = mul_hold(op);
    else if (m_left > 0) m_left--;
    if (eg && is_div)  d_left = div_hold(op);
    else if (d_left > 0) d_left--;
    last_grant = eg;
  endtask

  task automatic retry(input int op, input int exp_cycles, input string tag);
    int n = 0;
    do begin
      step(1, op, tag);
      n++;
    end while (!last_grant && n < 60);
    check(tag, "cycles to grant", n, exp_cycles);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, "R10");
  endtask

  task automatic finish_run();
    req_valid = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_op = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "grant in reset", grant, 0);
    check("R1", "mul_busy in reset", mul_busy, 0);
    check("R1", "div_busy in reset", div_busy, 0);
    check("R1", "add_busy in reset", add_busy, 0);
    rst_n = 1'b1;
    step(0, 0, "R1");

    // R2: add-class work, idle and alongside reservations
    step(1, 0, "R2");
    step(1, 8, "R2");
    step(1, 7, "R2");
    step(1, 2, "R2");
    step(1, 0, "R2");
    step(1, 8, "R2");
    idle(30);

    // R3: single-precision multiplies back to back
    step(1, 1, "R3");
    retry(3, 1, "R3");
    retry(1, 1, "R3");
    idle(2);

    // R4: double multiply and double MAC hold
    step(1, 2, "R4");
    retry(1, 4, "R4");
    step(1, 4, "R4");
    retry(3, 4, "R4");
    idle(2);

    // R5: fused double
    step(1, 5, "R5");
    retry(2, 5, "R5");
    idle(5);

    // R6 and R7: divider reservations
    step(1, 6, "R6");
    retry(6, 14, "R6");
    idle(20);
    step(1, 7, "R7");
    retry(6, 29, "R7");
    idle(20);

    // R8: refused requests do not extend a reservation
    step(1, 2, "R8");
    step(1, 5, "R8");
    idle(2);
    retry(1, 1, "R8");
    idle(5);
    step(1, 6, "R8");
    step(1, 7, "R8");
    idle(11);
    retry(6, 2, "R8");
    idle(20);

    // R9: independence of multiply and divide
    step(1, 7, "R9");
    retry(2, 1, "R9");
    retry(5, 4, "R9");
    idle(30);
    step(1, 5, "R9");
    retry(6, 1, "R9");
    idle(20);

    // R10: invalid and unused codes
    for (int op = 9; op < 16; op++) step(1, op, "R10");
    step(0, 2, "R10");
    step(0, 7, "R10");
    step(0, 0, "R10");
    retry(1, 1, "R10");

    done = 1;
    finish_run();
  end

endmodule